// File: doc/BRIEF.md
# Pipeline Operand Forwarding Selector

This block decides, for the instruction about to execute in a five-stage in-order pipeline, where each of its two ALU operands should come from. Each operand can come from the register-file read value, from the result held one stage ahead (execute/memory boundary), or from the result held two stages ahead (memory/writeback boundary). When both older stages write the source register, the newer result wins. A register index of zero is hard-wired to read as zero, so it is never forwarded.

The block also drives a one-bit select for store write data. A store in the memory stage takes its data from the writeback stage when the instruction directly ahead of it, usually a load, writes the register that the store is about to write to memory. The block has no clock and no state. Every output is a pure function of the current pipeline-register fields, which a surrounding datapath supplies and whose operand multiplexers it drives.

Top module: `fwd_unit`

## Requirements
- R1: `fwd_a_sel` is 2'b10 when `exm_wr_en` is 1, `exm_dst_idx` is nonzero and `exm_dst_idx` equals `idex_src_a_idx`.
- R2: `fwd_b_sel` is 2'b10 when `exm_wr_en` is 1, `exm_dst_idx` is nonzero and `exm_dst_idx` equals `idex_src_b_idx`.
- R3: An operand select is 2'b01 when `mwb_wr_en` is 1, `mwb_dst_idx` is nonzero, it equals that operand's source index, and the R1/R2 condition for that operand is false.
- R4: When both stages write the same nonzero source index, the select is 2'b10 (the newer result wins).
- R5: A stage whose write flag is 0 never causes forwarding, whatever its destination index.
- R6: A source index of 0 always yields select 2'b00.
- R7: In every other case the select is 2'b00 (register-file value), and the value 2'b11 never occurs.
- R8: `store_fwd_sel` is 1 when `mwb_wr_en` is 1, `exm_is_store` is 1, `mwb_dst_idx` equals `exm_store_idx`, and that index is nonzero.
- R9: `store_fwd_sel` is 0 whenever any one of the R8 conditions fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_src_a_idx | input | 5 | First source register index of the executing instruction |
| idex_src_b_idx | input | 5 | Second source register index of the executing instruction |
| exm_wr_en | input | 1 | Instruction in memory stage writes a register |
| exm_dst_idx | input | 5 | Destination index of instruction in memory stage |
| exm_is_store | input | 1 | Instruction in memory stage writes data memory |
| exm_store_idx | input | 5 | Register whose value the memory-stage store writes |
| mwb_wr_en | input | 1 | Instruction in writeback stage writes a register |
| mwb_dst_idx | input | 5 | Destination index of instruction in writeback stage |
| fwd_a_sel | output | 2 | Operand A source: 00 register file, 01 writeback, 10 memory stage |
| fwd_b_sel | output | 2 | Operand B source, same encoding |
| store_fwd_sel | output | 1 | 1 takes store data from the writeback stage |

## Verification
Every result is combinational, so it is due in the same cycle as its stimulus, with zero register delay. The bench changes the inputs on the falling clock edge and samples the outputs one nanosecond later, well before the next rising edge. Each input pattern therefore has settled when it is checked, and no check can see a value left over from the pattern before. Random indices are drawn from a narrow range, so matches, zero indices and double matches on the same source occur often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        FWD_REGFILE  = 2'b00,
        FWD_FROM_WB  = 2'b01,
        FWD_FROM_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        fwd_sel_e sel_a;
        fwd_sel_e sel_b;
        logic     store_sel;
    } fwd_out_t;
endpackage

// File: rtl/fwd_stage_hit.sv
module fwd_stage_hit #(
    parameter int IDX_W = 5
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] src_idx,
    output logic             hit
);
    // A producer counts only if it writes, is not the zero register and matches
    assign hit = wr_en && (dst_idx != '0) && (dst_idx == src_idx);
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
(
    input  logic     mem_hit,
    input  logic     wb_hit,
    output fwd_sel_e sel
);
    // Newer producer (memory stage) takes priority over writeback
    always_comb begin
        if (mem_hit)     sel = FWD_FROM_MEM;
        else if (wb_hit) sel = FWD_FROM_WB;
        else             sel = FWD_REGFILE;
    end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
    parameter int IDX_W = 5
) (
    input  logic             wb_wr_en,
    input  logic [IDX_W-1:0] wb_dst_idx,
    input  logic             mem_is_store,
    input  logic [IDX_W-1:0] mem_store_idx,
    output logic             sel
);
    logic gated_wr;

    assign gated_wr = wb_wr_en & mem_is_store;

    fwd_stage_hit #(.IDX_W(IDX_W)) i_hit (
        .wr_en   (gated_wr),
        .dst_idx (wb_dst_idx),
        .src_idx (mem_store_idx),
        .hit     (sel)
    );
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             [IDX_W-1:0] idex_src_a_idx,
    input  logic             [IDX_W-1:0] idex_src_b_idx,
    input  logic                         exm_wr_en,
    input  logic             [IDX_W-1:0] exm_dst_idx,
    input  logic                         exm_is_store,
    input  logic             [IDX_W-1:0] exm_store_idx,
    input  logic                         mwb_wr_en,
    input  logic             [IDX_W-1:0] mwb_dst_idx,
    output logic             [1:0]       fwd_a_sel,
    output logic             [1:0]       fwd_b_sel,
    output logic                         store_fwd_sel
);
    localparam int NUM_OPS = 2;

    logic [IDX_W-1:0] src_idx [NUM_OPS];
    fwd_sel_e         op_sel  [NUM_OPS];
    logic             st_sel;
    fwd_out_t         out_d;

    assign src_idx[0] = idex_src_a_idx;
    assign src_idx[1] = idex_src_b_idx;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        logic mem_hit;
        logic wb_hit;

        fwd_stage_hit #(.IDX_W(IDX_W)) i_mem_hit (
            .wr_en   (exm_wr_en),
            .dst_idx (exm_dst_idx),
            .src_idx (src_idx[g]),
            .hit     (mem_hit)
        );

        fwd_stage_hit #(.IDX_W(IDX_W)) i_wb_hit (
            .wr_en   (mwb_wr_en),
            .dst_idx (mwb_dst_idx),
            .src_idx (src_idx[g]),
            .hit     (wb_hit)
        );

        fwd_operand_sel i_sel (
            .mem_hit (mem_hit),
            .wb_hit  (wb_hit),
            .sel     (op_sel[g])
        );
    end

    fwd_store_sel #(.IDX_W(IDX_W)) i_store (
        .wb_wr_en      (mwb_wr_en),
        .wb_dst_idx    (mwb_dst_idx),
        .mem_is_store  (exm_is_store),
        .mem_store_idx (exm_store_idx),
        .sel           (st_sel)
    );

    // Output bundle; no state, so the _d value drives the ports directly
    always_comb begin
        out_d.sel_a     = op_sel[0];
        out_d.sel_b     = op_sel[1];
        out_d.store_sel = st_sel;
    end

    assign fwd_a_sel     = out_d.sel_a;
    assign fwd_b_sel     = out_d.sel_b;
    assign store_fwd_sel = out_d.store_sel;
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int IDX_W = 5
) (
    input logic [IDX_W-1:0] idex_src_a_idx,
    input logic [IDX_W-1:0] idex_src_b_idx,
    input logic             exm_wr_en,
    input logic [IDX_W-1:0] exm_dst_idx,
    input logic             exm_is_store,
    input logic [IDX_W-1:0] exm_store_idx,
    input logic             mwb_wr_en,
    input logic [IDX_W-1:0] mwb_dst_idx,
    input logic [1:0]       fwd_a_sel,
    input logic [1:0]       fwd_b_sel,
    input logic             store_fwd_sel
);
    always_comb begin
        AST_MEM_HIT_A: assert (!(exm_wr_en && exm_dst_idx != '0 && exm_dst_idx == idex_src_a_idx) || fwd_a_sel == 2'b10); // R1
        AST_MEM_HIT_B: assert (!(exm_wr_en && exm_dst_idx != '0 && exm_dst_idx == idex_src_b_idx) || fwd_b_sel == 2'b10); // R2
        AST_WB_SEL_A: assert (fwd_a_sel != 2'b01 || (mwb_wr_en && mwb_dst_idx == idex_src_a_idx)); // R3
        AST_IDLE_STAGES: assert (exm_wr_en || mwb_wr_en || (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00)); // R5
        AST_ZERO_SRC_A: assert (idex_src_a_idx != '0 || fwd_a_sel == 2'b00); // R6
        AST_ZERO_SRC_B: assert (idex_src_b_idx != '0 || fwd_b_sel == 2'b00); // R6
        AST_LEGAL_SEL: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11); // R7
        AST_STORE_COND: assert (!store_fwd_sel || (exm_is_store && mwb_wr_en && exm_store_idx != '0 && exm_store_idx == mwb_dst_idx)); // R9
    end
endmodule

bind fwd_unit fwd_unit_chk #(.IDX_W(IDX_W)) i_fwd_unit_chk (
    .idex_src_a_idx (idex_src_a_idx),
    .idex_src_b_idx (idex_src_b_idx),
    .exm_wr_en      (exm_wr_en),
    .exm_dst_idx    (exm_dst_idx),
    .exm_is_store   (exm_is_store),
    .exm_store_idx  (exm_store_idx),
    .mwb_wr_en      (mwb_wr_en),
    .mwb_dst_idx    (mwb_dst_idx),
    .fwd_a_sel      (fwd_a_sel),
    .fwd_b_sel      (fwd_b_sel),
    .store_fwd_sel  (store_fwd_sel)
);

// File: tb/test_fwd_unit.sv
module test_fwd_unit;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic [IDX_W-1:0] src_a, src_b, exm_dst, exm_st, mwb_dst;
    logic             exm_wr, exm_st_en, mwb_wr;
    logic [1:0]       sel_a, sel_b;
    logic             st_sel;
    int               n_checks = 0;
    int               n_errors = 0;
    bit               done = 1'b0;

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    fwd_unit #(.IDX_W(IDX_W)) i_fwd_unit (
        .idex_src_a_idx (src_a),
        .idex_src_b_idx (src_b),
        .exm_wr_en      (exm_wr),
        .exm_dst_idx    (exm_dst),
        .exm_is_store   (exm_st_en),
        .exm_store_idx  (exm_st),
        .mwb_wr_en      (mwb_wr),
        .mwb_dst_idx    (mwb_dst),
        .fwd_a_sel      (sel_a),
        .fwd_b_sel      (sel_b),
        .store_fwd_sel  (st_sel)
    );

    function automatic logic [1:0] exp_sel(logic [IDX_W-1:0] src);
        if (exm_wr && exm_dst != 0 && exm_dst == src) return 2'b10;
        if (mwb_wr && mwb_dst != 0 && mwb_dst == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string sel_tag(logic [IDX_W-1:0] src, bit is_b);
        if (src == 0) return "R6";
        if (exm_dst == src && mwb_dst == src && exm_wr && mwb_wr) return "R4";
        if (exm_wr && exm_dst == src) return is_b ? "R2" : "R1";
        if (mwb_wr && mwb_dst == src) return "R3";
        if (exm_dst == src || mwb_dst == src) return "R5";
        return "R7";
    endfunction

    function automatic logic exp_st();
        return mwb_wr && exm_st_en && mwb_dst == exm_st && exm_st != 0;
    endfunction

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b (a=%0d b=%0d exd=%0d exw=%b wbd=%0d wbw=%b st=%b sti=%0d)",
                     tag, act, exp, src_a, src_b, exm_dst, exm_wr, mwb_dst, mwb_wr, exm_st_en, exm_st);
        end
    endtask

    task automatic apply(logic [IDX_W-1:0] a, logic [IDX_W-1:0] b, logic ew, logic [IDX_W-1:0] ed,
                         logic ww, logic [IDX_W-1:0] wd, logic se, logic [IDX_W-1:0] si);
        @(negedge clk);
        src_a = a; src_b = b; exm_wr = ew; exm_dst = ed;
        mwb_wr = ww; mwb_dst = wd; exm_st_en = se; exm_st = si;
        #1;   // combinational: due in the same cycle
        check(sel_tag(src_a, 1'b0), sel_a, exp_sel(src_a));
        check(sel_tag(src_b, 1'b1), sel_b, exp_sel(src_b));
        check(exp_st() ? "R8" : "R9", {1'b0, st_sel}, {1'b0, exp_st()});
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R7: all-zero idle pattern
        apply(0, 0, 0, 0, 0, 0, 0, 0);
        // R1, R2: memory-stage producer feeds both operands
        apply(2, 2, 1, 2, 0, 0, 0, 0);
        // R3: writeback producer only
        apply(3, 7, 0, 9, 1, 7, 0, 0);
        // R4: both stages write the same source, newer wins
        apply(1, 1, 1, 1, 1, 1, 0, 0);
        // R5: matching indices but write flags low
        apply(4, 4, 0, 4, 0, 4, 0, 0);
        // R6: zero register never forwarded
        apply(0, 0, 1, 0, 1, 0, 1, 0);
        // R8: load followed by store of the loaded register
        apply(6, 8, 0, 0, 1, 5, 1, 5);
        // R9: each store condition failing in turn
        apply(6, 8, 0, 0, 0, 5, 1, 5);
        apply(6, 8, 0, 0, 1, 5, 0, 5);
        apply(6, 8, 0, 0, 1, 5, 1, 4);
        // Constrained random: narrow index range to force matches
        for (int i = 0; i < 3000; i++) begin
            apply(IDX_W'($urandom_range(0, 3)), IDX_W'($urandom_range(0, 3)),
                  1'($urandom), IDX_W'($urandom_range(0, 3)),
                  1'($urandom), IDX_W'($urandom_range(0, 3)),
                  1'($urandom), IDX_W'($urandom_range(0, 3)));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule